// File: doc/BRIEF.md
# One-Time-Programmable Region Window Controller

This block guards a small one-time-programmable (OTP) byte region that sits outside the main flash array. It watches the decoded command stream of a serial flash front end. A dedicated entry opcode opens an access window. While the window is open, the ordinary read and program opcodes are steered to the OTP region, and the main array is cut off completely. A dedicated exit opcode, a software reset sequence or a power-on reset closes the window again.

The region holds 512 bytes, and the block models them as an array whose erased state is all ones. A program can only clear bits, so the stored byte becomes the old value AND the new value. Two lock sources make the region read-only: a permanent user lock-down, which is set by a lock request while write enable is set, and a factory lock strap. A program attempted under either lock leaves the contents alone and raises a program-fail flag.

Commands arrive on a valid/ready stream. Read data leaves on a second valid/ready stream. A read response is held, with its data frozen, until the consumer takes it. While a response is stalled, `cmd_ready` stays low, so no command is lost. Control and status signals are plain levels.

Top module: `otp_window_ctl`

## Requirements
- R1: After reset the window is closed (`otp_sel`=0, `main_grant`=1), `lock_down`=0, `prog_fail`=0, `rsp_valid`=0 and `cmd_ready`=1.
- R2: An accepted opcode B1h opens the window and an accepted opcode C1h closes it. `otp_sel` and `main_grant` change in the cycle after acceptance, and `main_grant` is 0 while the window is open.
- R3: With the window open, an accepted read (opcode 03h, or 0Bh when fast reads are enabled) returns the byte at `cmd_addr[8:0]` on `rsp_data`, with `rsp_valid` set in the cycle after acceptance. Never-programmed bytes read as FFh.
- R4: An address with any of bits 31..9 set is outside the region. A read of it returns FFh, and a program to it changes no byte and leaves `prog_fail` unchanged.
- R5: With the window open and `wel`=1, an accepted program (opcode 02h) to an unlocked region stores old AND `cmd_wdata` and clears `prog_fail`.
- R6: A program with `wel`=0 changes no byte and leaves `prog_fail` unchanged.
- R7: `lock_req` sampled together with `wel`=1 sets `lock_down` permanently. A software reset does not clear it, and `lock_req` with `wel`=0 has no effect.
- R8: An in-range program with `wel`=1 while `lock_down` or `factory_lock` is set changes no byte and sets `prog_fail` in the cycle after acceptance.
- R9: Opcode 66h accepted directly before opcode 99h closes the window. A 99h alone, or one separated from the 66h by another command, leaves the window as it was.
- R10: With the window closed, reads produce no response and programs change no OTP byte.
- R11: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_data` holds its value and `cmd_ready` is 0.
- R12: A program accepted in the same cycle as a valid lock request is judged against the lock state before that request, so it succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | 32 | Command byte address |
| cmd_wdata | input | 8 | Program data byte |
| wel | input | 1 | Write-enable latch state |
| lock_req | input | 1 | Request for permanent lock-down |
| factory_lock | input | 1 | Factory lock strap |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data byte |
| otp_sel | output | 1 | Window open, accesses go to OTP |
| main_grant | output | 1 | Main array may serve commands |
| lock_down | output | 1 | User lock-down status |
| prog_fail | output | 1 | Last judged program was rejected |

## Verification
Two pairs of events are driven into the same clock edge. In the first, a program is issued in the very cycle a valid lock request arrives. The bench judges it as a success: the byte changes, `prog_fail` stays 0, and `lock_down` rises afterwards. In the second, a read response is left stalled across several cycles. The bench expects the response data to stay frozen and `cmd_ready` to stay low, and it compares the data only when the consumer finally takes it.

// File: rtl/otp_win_pkg.sv
package otp_win_pkg;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_FREAD  = 8'h0B;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_OPEN   = 8'hB1;
  localparam logic [7:0] OP_CLOSE  = 8'hC1;
  localparam logic [7:0] OP_RSTEN  = 8'h66;
  localparam logic [7:0] OP_RST    = 8'h99;

  typedef enum logic [2:0] {
    K_NONE,
    K_READ,
    K_PROG,
    K_OPEN,
    K_CLOSE,
    K_RSTEN,
    K_RST
  } cmd_kind_e;
endpackage

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_win_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 9,
  parameter bit FAST_EN = 1'b1
) (
  input  logic [7:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output cmd_kind_e         kind,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  logic is_fast;

  generate
    if (FAST_EN) begin : g_fast
      assign is_fast = (op == OP_FREAD);
    end else begin : g_nofast
      assign is_fast = 1'b0;
    end
  endgenerate

  always_comb begin
    kind = K_NONE;
    if (op == OP_READ || is_fast) kind = K_READ;
    else if (op == OP_PROG)       kind = K_PROG;
    else if (op == OP_OPEN)       kind = K_OPEN;
    else if (op == OP_CLOSE)      kind = K_CLOSE;
    else if (op == OP_RSTEN)      kind = K_RSTEN;
    else if (op == OP_RST)        kind = K_RST;
  end

  assign idx      = addr[IDX_W-1:0];
  assign in_range = (addr[ADDR_W-1:IDX_W] == '0);
endmodule

// File: rtl/otp_mode_ctl.sv
module otp_mode_ctl
  import otp_win_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  cmd_kind_e kind,
  input  logic      in_range,
  input  logic      wel,
  input  logic      lock_req,
  input  logic      factory_lock,
  output logic      win_open,
  output logic      lock_down,
  output logic      prog_fail,
  output logic      wr_en,
  output logic      rd_en
);
  logic rst_armed;
  logic locked;
  logic prog_judged;

  assign locked      = lock_down | factory_lock;
  assign prog_judged = fire && (kind == K_PROG) && win_open && wel && in_range;
  assign wr_en       = prog_judged && !locked;
  assign rd_en       = fire && (kind == K_READ) && win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open  <= 1'b0;
      rst_armed <= 1'b0;
    end else if (fire) begin
      rst_armed <= (kind == K_RSTEN);
      case (kind)
        K_OPEN:  win_open <= 1'b1;
        K_CLOSE: win_open <= 1'b0;
        K_RST:   if (rst_armed) win_open <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_down <= 1'b0;
    else if (lock_req && wel) lock_down <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_fail <= 1'b0;
    else if (prog_judged) prog_fail <= locked;
  end
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              in_range,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[idx] <= cells[idx] & wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '1;
    else if (rd_en) rdata <= in_range ? cells[idx] : '1;
  end
endmodule

// File: rtl/otp_window_ctl.sv
module otp_window_ctl
  import otp_win_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 512,
  parameter int DATA_W  = 8,
  parameter bit FAST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              wel,
  input  logic              lock_req,
  input  logic              factory_lock,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              otp_sel,
  output logic              main_grant,
  output logic              lock_down,
  output logic              prog_fail
);
  localparam int IDX_W = $clog2(DEPTH);

  cmd_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             fire;
  logic             win_open;
  logic             wr_en;
  logic             rd_en;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  otp_cmd_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FAST_EN(FAST_EN)) u_dec (
    .op(cmd_op), .addr(cmd_addr), .kind(kind), .idx(idx), .in_range(in_range)
  );

  otp_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .fire(fire), .kind(kind), .in_range(in_range),
    .wel(wel), .lock_req(lock_req), .factory_lock(factory_lock),
    .win_open(win_open), .lock_down(lock_down), .prog_fail(prog_fail),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  otp_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .in_range(in_range),
    .idx(idx), .wdata(cmd_wdata), .rdata(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else if (rd_en) rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;
  end

  assign otp_sel    = win_open;
  assign main_grant = !win_open;
endmodule

// File: rtl/otp_window_chk.sv
module otp_window_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wel,
  input logic              factory_lock,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              otp_sel,
  input logic              lock_down,
  input logic              prog_fail
);
  logic acc;
  logic acc_read;
  assign acc      = cmd_valid && cmd_ready;
  assign acc_read = acc && (cmd_op == 8'h03 || cmd_op == 8'h0B);

  // R2
  open_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 8'hB1) |=> otp_sel);
  // R2
  close_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 8'hC1) |=> !otp_sel);
  // R3
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_read && otp_sel) |=> rsp_valid);
  // R10
  closed_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(acc_read && otp_sel));
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> (rsp_valid && !rsp_ready));
  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_down |=> lock_down);
  // R8
  locked_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 8'h02 && otp_sel && wel && (lock_down || factory_lock)
     && cmd_addr[ADDR_W-1:9] == '0) |=> prog_fail);
endmodule

bind otp_window_ctl otp_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .wel(wel), .factory_lock(factory_lock),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .otp_sel(otp_sel), .lock_down(lock_down), .prog_fail(prog_fail)
);

// File: tb/otp_window_ctl_tb.sv
module otp_window_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_op = 8'h00;
  logic [31:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        wel = 1'b0;
  logic        lock_req = 1'b0;
  logic        factory_lock = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        otp_sel, main_grant, lock_down, prog_fail;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mem [512];
  logic m_open = 1'b0, m_lock = 1'b0, m_fail = 1'b0, m_arm = 1'b0;
  logic [7:0] exp_q [$];
  logic [7:0] held;

  always #5 clk = ~clk;

  otp_window_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wel(wel),
    .lock_req(lock_req), .factory_lock(factory_lock), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .otp_sel(otp_sel),
    .main_grant(main_grant), .lock_down(lock_down), .prog_fail(prog_fail)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: each response handshake pops one expected byte
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected response", {24'h0, rsp_data}, 32'hDEAD);
      end else begin
        check("R3 response data", {24'h0, rsp_data}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  // Driver: starts and ends at a falling edge; updates the model at acceptance
  task automatic send(input logic [7:0] op, input logic [31:0] addr, input logic [7:0] data);
    logic inr;
    cmd_op = op; cmd_addr = addr; cmd_wdata = data; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    inr = (addr[31:9] == '0);
    case (op)
      8'h03, 8'h0B: if (m_open) exp_q.push_back(inr ? m_mem[addr[8:0]] : 8'hFF);
      8'h02: if (m_open && wel && inr) begin
        if (m_lock || factory_lock) m_fail = 1'b1;
        else begin m_mem[addr[8:0]] &= data; m_fail = 1'b0; end
      end
      8'hB1: m_open = 1'b1;
      8'hC1: m_open = 1'b0;
      8'h99: if (m_arm) m_open = 1'b0;
      default: ;
    endcase
    m_arm = (op == 8'h66);
    if (lock_req && wel) m_lock = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic state(input string tag);
    check({tag, " otp_sel"}, {31'h0, otp_sel}, {31'h0, m_open});
    check({tag, " main_grant"}, {31'h0, main_grant}, {31'h0, !m_open});
    check({tag, " lock_down"}, {31'h0, lock_down}, {31'h0, m_lock});
    check({tag, " prog_fail"}, {31'h0, prog_fail}, {31'h0, m_fail});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("watchdog expired", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) m_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    state("R1");
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1 cmd_ready", {31'h0, cmd_ready}, 32'h1);

    // R10 window closed: no response, program does not touch OTP
    wel = 1'b1;
    send(8'h03, 32'h5, 8'h00);
    check("R10 no rsp when closed", {31'h0, rsp_valid}, 32'h0);
    send(8'h02, 32'h5, 8'h00);
    // R2 open
    send(8'hB1, 32'h0, 8'h00);
    state("R2 open");
    send(8'h03, 32'h5, 8'h00);          // R10 byte still erased
    // R5 AND programming
    send(8'h02, 32'h5, 8'hA5);
    send(8'h03, 32'h5, 8'h00);
    send(8'h02, 32'h5, 8'h3C);
    send(8'h0B, 32'h5, 8'h00);          // R5 expects 24h
    state("R5");
    // R6 wel low
    wel = 1'b0;
    send(8'h02, 32'h6, 8'h00);
    send(8'h03, 32'h6, 8'h00);
    state("R6");
    wel = 1'b1;
    // R4 out of range
    send(8'h02, 32'h205, 8'h00);
    state("R4");
    send(8'h03, 32'h205, 8'h00);
    send(8'h03, 32'h5, 8'h00);
    // R2 close, R9 reset sequences
    send(8'hC1, 32'h0, 8'h00);
    state("R2 close");
    send(8'hB1, 32'h0, 8'h00);
    send(8'h99, 32'h0, 8'h00);
    state("R9 lone 99h");
    send(8'h66, 32'h0, 8'h00);
    send(8'h03, 32'h6, 8'h00);
    send(8'h99, 32'h0, 8'h00);
    state("R9 split");
    send(8'h66, 32'h0, 8'h00);
    send(8'h99, 32'h0, 8'h00);
    state("R9 reset");
    send(8'hB1, 32'h0, 8'h00);

    // R11 back-pressure
    rsp_ready = 1'b0;
    send(8'h03, 32'h5, 8'h00);
    check("R11 rsp_valid held", {31'h0, rsp_valid}, 32'h1);
    check("R11 cmd_ready low", {31'h0, cmd_ready}, 32'h0);
    held = rsp_data;
    repeat (3) @(negedge clk);
    check("R11 data stable", {24'h0, rsp_data}, {24'h0, held});
    check("R11 still stalled", {31'h0, cmd_ready}, 32'h0);
    rsp_ready = 1'b1;
    @(negedge clk);

    // R8 factory lock
    factory_lock = 1'b1;
    send(8'h02, 32'h7, 8'h00);
    state("R8 factory");
    send(8'h03, 32'h7, 8'h00);
    factory_lock = 1'b0;
    send(8'h02, 32'h7, 8'hF0);
    state("R8 clear");
    send(8'h03, 32'h7, 8'h00);

    // R7 lock request without wel is ignored
    wel = 1'b0; lock_req = 1'b1;
    @(negedge clk);
    lock_req = 1'b0; wel = 1'b1;
    state("R7 no wel");

    // R12 program in the lock-request cycle succeeds
    lock_req = 1'b1;
    send(8'h02, 32'h8, 8'h0F);
    lock_req = 1'b0;
    state("R12");
    send(8'h03, 32'h8, 8'h00);

    // R8 user lock rejects, R7 survives software reset
    send(8'h02, 32'h9, 8'h00);
    state("R8 user lock");
    send(8'h03, 32'h9, 8'h00);
    send(8'h66, 32'h0, 8'h00);
    send(8'h99, 32'h0, 8'h00);
    state("R7 after reset");

    repeat (2) @(negedge clk);
    check("R3 all responses seen", exp_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule